// File: doc/BRIEF.md
# Saturating Element Clamp Stage

This stage sits behind an integer datapath that produces its results with spare headroom. It accepts one wide two's-complement intermediate value per cycle. That value has already been computed at the larger of the source and destination element widths. The stage narrows the value to a destination element of 8, 16, 32 or 64 bits. When saturation is requested, a value that does not fit is pinned to the nearest representable bound instead of wrapping. The bounds are signed or unsigned, as selected.

Alongside the element, the stage builds a 4-bit condition field. It holds less-than, greater-than and equal flags taken from the narrowed element, plus an overflow flag. The overflow flag tells, for this element alone, whether the clamp changed the value. No sticky summary overflow is read or written. A request that combines saturation with the overflow-enable instruction form is flagged as illegal. Every result is registered, so the outputs for an input appear on the following cycle.

Top module: `sat_clamp_stage`

## Requirements
- R1: With saturation on and unsigned mode (`sat_signed`=0), the element equals the input clamped to 0 .. 2^w-1, where w is the destination width. The input is always read as a signed two's-complement value, so a negative input gives 0.
- R2: With saturation on and signed mode (`sat_signed`=1), the element equals the input clamped to -2^(w-1) .. 2^(w-1)-1. It is output as w-bit two's complement.
- R3: With saturation on, an input that already lies inside the selected range passes through unchanged (low w bits), and no overflow is flagged.
- R4: `dst_wcode` selects w: 00 = 64, 01 = 32, 10 = 16, 11 = 8. Output bits at position w and above are always zero.
- R5: With `cond_en`=1, condition bit 0 (overflow) is 1 exactly when the clamp altered the value. It is always 0 when saturation is off.
- R6: With `cond_en`=1, bit 3 = lt, bit 2 = gt and bit 1 = eq describe the output element compared with zero. The element is read as signed in signed mode and as unsigned otherwise, so lt is never set in unsigned mode.
- R7: With `cond_en`=0 the condition output is all zero.
- R8: When `sat_en` and `oe_form` are both 1, `out_illegal` is 1 and both the element and the condition field are zero. Otherwise `out_illegal` is 0.
- R9: Outputs for an input presented with `in_valid`=1 appear exactly one clock later with `out_valid`=1. A cycle with `in_valid`=0 yields `out_valid`=0 on the next cycle.
- R10: With saturation off, the element is the input truncated to its low w bits, with no clamping.
- R11: While `rst` is high, all outputs are zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input value present this cycle |
| in_result | input | IN_W (66) | Wide two's-complement intermediate result |
| sat_en | input | 1 | Saturation requested |
| sat_signed | input | 1 | 1 = signed clamp, 0 = unsigned clamp |
| dst_wcode | input | 2 | Destination width code (00=64, 01=32, 10=16, 11=8) |
| cond_en | input | 1 | Produce the condition field |
| oe_form | input | 1 | Instruction uses the overflow-enable form |
| out_valid | output | 1 | Registered result present |
| out_elem | output | MAX_W (64) | Clamped, truncated, zero-filled element |
| out_cond | output | 4 | {lt, gt, eq, ovf} |
| out_illegal | output | 1 | Illegal saturation/overflow-enable combination |

## Verification
Every result of this stage (element, condition field, illegal flag and valid) comes from a single register level. All of them are therefore due on the first rising edge after the input is presented. The bench drives each input on a falling edge and computes the expected values from the requirements at that moment. It then compares the outputs on the next falling edge, half a period after the registering edge, so sampling never races the update. An idle cycle is checked the same way, to confirm that valid drops one cycle after the input does.

// File: rtl/sat_clamp_pkg.sv
package sat_clamp_pkg;

  // Destination width selector: each step halves the element width.
  typedef enum logic [1:0] {
    WC_FULL    = 2'b00,
    WC_HALF    = 2'b01,
    WC_QUARTER = 2'b10,
    WC_EIGHTH  = 2'b11
  } wcode_e;

  localparam int NUM_WCODES = 4;

  // Per-element condition field, MSB first.
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic ovf;
  } cond_t;

endpackage

// File: rtl/sat_bounds.sv
module sat_bounds
  import sat_clamp_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int IN_W  = 66
) (
  input  wcode_e                 wcode,
  input  logic                   is_signed,
  output logic signed [IN_W-1:0] lo,
  output logic signed [IN_W-1:0] hi,
  output logic [MAX_W-1:0]       mask
);

  localparam logic [IN_W-1:0] ONE = {{(IN_W-1){1'b0}}, 1'b1};

  logic [IN_W-1:0]  smax_t [NUM_WCODES];
  logic [IN_W-1:0]  smin_t [NUM_WCODES];
  logic [IN_W-1:0]  umax_t [NUM_WCODES];
  logic [MAX_W-1:0] mask_t [NUM_WCODES];

  // One set of constant bounds per width code.
  for (genvar i = 0; i < NUM_WCODES; i++) begin : g_w
    localparam int W = MAX_W >> i;
    localparam logic [IN_W-1:0] SMAX = (ONE << (W - 1)) - ONE;
    localparam logic [IN_W-1:0] UMAX = (ONE << W) - ONE;
    assign smax_t[i] = SMAX;
    assign smin_t[i] = ~SMAX;
    assign umax_t[i] = UMAX;
    assign mask_t[i] = UMAX[MAX_W-1:0];
  end

  always_comb begin
    mask = mask_t[wcode];
    if (is_signed) begin
      lo = $signed(smin_t[wcode]);
      hi = $signed(smax_t[wcode]);
    end else begin
      lo = '0;
      hi = $signed(umax_t[wcode]);
    end
  end

endmodule

// File: rtl/sat_limiter.sv
module sat_limiter #(
  parameter int IN_W = 66
) (
  input  logic signed [IN_W-1:0] value,
  input  logic signed [IN_W-1:0] lo,
  input  logic signed [IN_W-1:0] hi,
  input  logic                   enable,
  output logic signed [IN_W-1:0] limited,
  output logic                   hit
);

  logic above;
  logic below;

  assign above = value > hi;
  assign below = value < lo;

  always_comb begin
    limited = value;
    hit     = 1'b0;
    if (enable) begin
      if (above) begin
        limited = hi;
        hit     = 1'b1;
      end else if (below) begin
        limited = lo;
        hit     = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_flags.sv
module sat_flags
  import sat_clamp_pkg::*;
#(
  parameter int MAX_W = 64
) (
  input  logic [MAX_W-1:0] elem,
  input  logic [MAX_W-1:0] mask,
  input  logic             is_signed,
  input  logic             sat_hit,
  input  logic             enable,
  output cond_t            cond
);

  logic [MAX_W-1:0] top_bit;
  logic             negative;
  logic             zero;

  // Highest set bit of the width mask marks the element sign position.
  assign top_bit  = mask & ~(mask >> 1);
  assign negative = is_signed & (|(elem & top_bit));
  assign zero     = ~(|elem);

  always_comb begin
    cond = '0;
    if (enable) begin
      cond.lt  = negative;
      cond.gt  = ~negative & ~zero;
      cond.eq  = zero;
      cond.ovf = sat_hit;
    end
  end

endmodule

// File: rtl/sat_clamp_stage.sv
module sat_clamp_stage
  import sat_clamp_pkg::*;
#(
  parameter int MAX_W = 64,
  parameter int IN_W  = 66
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_result,
  input  logic            sat_en,
  input  logic            sat_signed,
  input  logic [1:0]      dst_wcode,
  input  logic            cond_en,
  input  logic            oe_form,
  output logic            out_valid,
  output logic [MAX_W-1:0] out_elem,
  output logic [3:0]      out_cond,
  output logic            out_illegal
);

  logic signed [IN_W-1:0] lo_b;
  logic signed [IN_W-1:0] hi_b;
  logic [MAX_W-1:0]       wmask;
  logic signed [IN_W-1:0] limited;
  logic                   hit;
  logic [MAX_W-1:0]       elem_n;
  cond_t                  cond_n;
  logic                   illegal_n;

  sat_bounds #(.MAX_W(MAX_W), .IN_W(IN_W)) u_bounds (
    .wcode     (wcode_e'(dst_wcode)),
    .is_signed (sat_signed),
    .lo        (lo_b),
    .hi        (hi_b),
    .mask      (wmask)
  );

  sat_limiter #(.IN_W(IN_W)) u_limit (
    .value   ($signed(in_result)),
    .lo      (lo_b),
    .hi      (hi_b),
    .enable  (sat_en),
    .limited (limited),
    .hit     (hit)
  );

  assign elem_n    = limited[MAX_W-1:0] & wmask;
  assign illegal_n = sat_en & oe_form;

  sat_flags #(.MAX_W(MAX_W)) u_flags (
    .elem      (elem_n),
    .mask      (wmask),
    .is_signed (sat_signed),
    .sat_hit   (hit),
    .enable    (cond_en),
    .cond      (cond_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_elem    <= '0;
      out_cond    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid & illegal_n;
      if (in_valid && !illegal_n) begin
        out_elem <= elem_n;
        out_cond <= cond_n;
      end else begin
        out_elem <= '0;
        out_cond <= '0;
      end
    end
  end

endmodule

// File: rtl/sat_clamp_chk.sv
module sat_clamp_chk #(
  parameter int MAX_W = 64,
  parameter int IN_W  = 66
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_result,
  input logic             sat_en,
  input logic             sat_signed,
  input logic [1:0]       dst_wcode,
  input logic             cond_en,
  input logic             oe_form,
  input logic             out_valid,
  input logic [MAX_W-1:0] out_elem,
  input logic [3:0]       out_cond,
  input logic             out_illegal
);

  assert_valid_follow_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drop_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_zero_fill_R4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((out_elem >> (MAX_W >> $past(dst_wcode))) == '0));

  assert_neg_to_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && !sat_signed && !oe_form && in_result[IN_W-1])
      |=> (out_elem == '0));

  assert_no_ovf_unsat_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_en) |=> !out_cond[0]);

  assert_unsigned_no_lt_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_signed) |=> !out_cond[3]);

  assert_one_relation_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(out_cond[3:1]) <= 1);

  assert_cond_off_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !cond_en) |=> (out_cond == 4'b0000));

  assert_illegal_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_en && oe_form) |=> (out_illegal && out_elem == '0));

  assert_legal_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !(sat_en && oe_form)) |=> !out_illegal);

endmodule

bind sat_clamp_stage sat_clamp_chk #(.MAX_W(MAX_W), .IN_W(IN_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_result   (in_result),
  .sat_en      (sat_en),
  .sat_signed  (sat_signed),
  .dst_wcode   (dst_wcode),
  .cond_en     (cond_en),
  .oe_form     (oe_form),
  .out_valid   (out_valid),
  .out_elem    (out_elem),
  .out_cond    (out_cond),
  .out_illegal (out_illegal)
);

// File: tb/tb_sat_clamp_stage.sv
`timescale 1ns/1ps
module tb_sat_clamp_stage;

  localparam int MAX_W = 64;
  localparam int IN_W  = 66;

  logic            clk = 1'b0;
  logic            rst;
  logic            in_valid;
  logic [IN_W-1:0] in_result;
  logic            sat_en, sat_signed, cond_en, oe_form;
  logic [1:0]      dst_wcode;
  logic            out_valid;
  logic [MAX_W-1:0] out_elem;
  logic [3:0]      out_cond;
  logic            out_illegal;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  sat_clamp_stage #(.MAX_W(MAX_W), .IN_W(IN_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_result(in_result),
    .sat_en(sat_en), .sat_signed(sat_signed), .dst_wcode(dst_wcode),
    .cond_en(cond_en), .oe_form(oe_form), .out_valid(out_valid),
    .out_elem(out_elem), .out_cond(out_cond), .out_illegal(out_illegal)
  );

  task automatic chk(input string req, input string what,
                     input logic [MAX_W-1:0] got, input logic [MAX_W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  function automatic void model(input logic [IN_W-1:0] v, input logic sg,
      input logic [1:0] wc, input logic ce, input logic se, input logic oe,
      output logic [MAX_W-1:0] e, output logic [3:0] c, output logic il);
    int w;
    logic signed [IN_W-1:0] sv, hi, lo, r;
    logic [MAX_W-1:0] m;
    logic sat, neg, zr;
    w   = MAX_W >> wc;
    sv  = $signed(v);
    sat = 1'b0;
    if (sg) begin
      hi = (66'sd1 <<< (w - 1)) - 66'sd1;
      lo = -(66'sd1 <<< (w - 1));
    end else begin
      hi = (66'sd1 <<< w) - 66'sd1;
      lo = 66'sd0;
    end
    r = sv;
    if (se) begin
      if (sv > hi) begin r = hi; sat = 1'b1; end
      else if (sv < lo) begin r = lo; sat = 1'b1; end
    end
    m   = (w == MAX_W) ? '1 : ((64'd1 << w) - 64'd1);
    e   = r[MAX_W-1:0] & m;
    neg = sg & e[w-1];
    zr  = (e == '0);
    c   = ce ? {neg, ~neg & ~zr, zr, sat} : 4'b0000;
    il  = se & oe;
    if (il) begin e = '0; c = 4'b0000; end
  endfunction

  // Drive on a falling edge, compare on the next falling edge.
  task automatic step(input string req, input logic [IN_W-1:0] v, input logic sg,
      input logic [1:0] wc, input logic ce, input logic se, input logic oe);
    logic [MAX_W-1:0] e;
    logic [3:0] c;
    logic il;
    in_valid = 1'b1; in_result = v; sat_signed = sg; dst_wcode = wc;
    cond_en = ce; sat_en = se; oe_form = oe;
    model(v, sg, wc, ce, se, oe, e, c, il);
    @(negedge clk);
    chk("R9", "valid", {63'd0, out_valid}, 64'd1);
    chk(req, "elem", out_elem, e);
    chk(req, "cond", {60'd0, out_cond}, {60'd0, c});
    chk(req, "illegal", {63'd0, out_illegal}, {63'd0, il});
  endtask

  function automatic logic [IN_W-1:0] sx(input longint x);
    return {{(IN_W-64){x[63]}}, x};
  endfunction

  initial begin
    #(20000 * 10);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [IN_W-1:0] v;
    int dummy;
    dummy = $urandom(32'h5A7C_1E0D);
    rst = 1'b1; in_valid = 1'b0; in_result = '1; sat_en = 1'b1;
    sat_signed = 1'b1; dst_wcode = 2'b11; cond_en = 1'b1; oe_form = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "valid", {63'd0, out_valid}, 64'd0);
    chk("R11", "elem", out_elem, 64'd0);
    chk("R11", "cond", {60'd0, out_cond}, 64'd0);
    chk("R11", "illegal", {63'd0, out_illegal}, 64'd0);
    rst = 1'b0;
    oe_form = 1'b0;

    // R1: unsigned 8-bit, above and below
    step("R1", sx(300), 1'b0, 2'b11, 1'b1, 1'b1, 1'b0);   // 0xFF, gt, ovf
    step("R1", sx(-5), 1'b0, 2'b11, 1'b1, 1'b1, 1'b0);    // 0, eq, ovf
    step("R1", 66'h1_0000_0000_0000_0000, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0); // 2^64 -> all ones
    // R2: signed bounds
    step("R2", sx(-40000), 1'b1, 2'b10, 1'b1, 1'b1, 1'b0); // 0x8000, lt, ovf
    step("R2", sx(40000), 1'b1, 2'b10, 1'b1, 1'b1, 1'b0);  // 0x7FFF
    step("R2", 66'h0_8000_0000_0000_0000, 1'b1, 2'b00, 1'b1, 1'b1, 1'b0); // 2^63 -> max
    // R3: in range passes through
    step("R3", sx(-1), 1'b1, 2'b01, 1'b1, 1'b1, 1'b0);     // 0xFFFFFFFF, lt, no ovf
    step("R3", sx(255), 1'b0, 2'b11, 1'b1, 1'b1, 1'b0);    // 0xFF exactly
    step("R3", sx(-128), 1'b1, 2'b11, 1'b1, 1'b1, 1'b0);   // 0x80 exactly
    // R4 / R10: truncation and zero fill without saturation
    step("R10", sx(64'h1234_5678_9ABC_DEF0), 1'b0, 2'b01, 1'b1, 1'b0, 1'b0);
    step("R4", sx(64'hFFFF_FFFF_FFFF_FF85), 1'b1, 2'b11, 1'b1, 1'b0, 1'b0);
    // R6: zero result, unsigned large value
    step("R6", sx(0), 1'b1, 2'b00, 1'b1, 1'b1, 1'b0);
    step("R6", sx(-7), 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);     // unsigned: gt, never lt
    // R7: condition disabled
    step("R7", sx(-40000), 1'b1, 2'b10, 1'b0, 1'b1, 1'b0);
    // R8: illegal combination, and overflow form without saturation
    step("R8", sx(300), 1'b0, 2'b11, 1'b1, 1'b1, 1'b1);
    step("R8", sx(300), 1'b0, 2'b11, 1'b1, 1'b0, 1'b1);
    // R9: idle cycle drops valid
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9", "idle valid", {63'd0, out_valid}, 64'd0);

    // R5 and mixed: constrained random near boundaries
    for (int i = 0; i < 400; i++) begin
      logic [1:0] wc;
      logic sg, se;
      int w;
      wc = 2'($urandom_range(0, 3));
      sg = 1'($urandom_range(0, 1));
      se = ($urandom_range(0, 3) != 0);
      w  = MAX_W >> wc;
      case ($urandom_range(0, 2))
        0: v = {2'($urandom), $urandom, $urandom};
        1: v = sx(longint'($urandom_range(0, 6)) - 3) + (66'd1 << (w - 1));
        default: v = sx(longint'($urandom_range(0, 6)) - 3) - (66'd1 << (w - 1));
      endcase
      step(se ? (sg ? "R2" : "R1") : "R10", v, sg, wc,
           1'($urandom_range(0, 1)), se, ($urandom_range(0, 7) == 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule